// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt lines into three banks of 32. Each bank has a mask, and the mask can only be changed through a write-one-to-set port and a write-one-to-clear port. Software reads a pending word per bank, which holds the lines that are asserted and not masked. The controller drives one request line to the processor.

When nothing is being serviced and some line is pending, the lowest-numbered pending line becomes the current interrupt and the request line rises. That choice stays frozen until software writes an acknowledge to the control register. Software reads the current line number from the sorted register. If the latched line has stopped pending by the time of the read, the sorted register sets its upper bits to flag a spurious event.

A soft reset is started from the configuration register and lasts a fixed number of cycles. A status bit reports when it has finished. The configuration register also holds an auto-idle bit, which the block only stores. The register bus is a single-cycle bus: writes take effect at the clock edge and read data is combinational from the address.

Top module: `banked_intc`

## Requirements
- R1: After reset, every mask bit is 1, `irq_out` is 0, every pending word (offset 0x98 + 0x20·b) reads 0, and the status register (0x14) reads 1 in bit 0.
- R2: The pending word of bank b (offset 0x98 + 0x20·b, b = 0..2) reads `src_lvl[32b+31:32b] & ~mask_b` in the same cycle.
- R3: A write to the set port of bank b (offset 0x8C + 0x20·b) sets each mask bit written as 1 and keeps every other bit. The mask is read back at offset 0x84 + 0x20·b.
- R4: A write to the clear port of bank b (offset 0x88 + 0x20·b) clears each mask bit written as 1 and keeps every other bit. A write to the mask readback offset 0x84 + 0x20·b changes nothing.
- R5: When no interrupt is current and some line is pending, the lowest-numbered pending line is latched one cycle later and `irq_out` goes high. The sorted register (0x40) then reads that number in bits [6:0], with bits [31:7] zero.
- R6: The current interrupt and `irq_out` stay unchanged whatever the sources do, and after a control write (0x48) with bit 0 equal to 0, until a control write with bit 0 equal to 1. One cycle after that acknowledge, the next lowest pending line is latched.
- R7: If no interrupt is current, or the current line is no longer pending, the sorted register reads bits [31:7] all 1. Bits [6:0] then hold the last latched number.
- R8: A configuration write (0x10) with bit 1 set starts a soft reset. Status bit 0 reads 0 for 4 cycles and configuration bit 1 reads 1 during that time. All masks return to 1, `irq_out` drops, and auto-idle returns to 0.
- R9: While a soft reset is in progress, every write other than a configuration write is ignored.
- R10: Configuration bit 0 is the auto-idle enable. It reads back what was written and is 0 after reset.
- R11: The revision register (0x00) reads 0x40: major version 4 in bits [7:4] and minor version 0 in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 96 | Level-sensitive interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong mask bit shows up in the same cycle as a wrong pending word. It also shows up one cycle later as the wrong source in the sorted register. A current-interrupt latch that drops or reselects early shows as `irq_out` or the sorted number changing between two reads with no acknowledge in between. A soft-reset counter that is off shows as the status bit reading 1 before or after the fourth busy cycle. Writes made inside the busy window that are not blocked show as a mask that is no longer all ones once the reset has finished.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_SRC     = 96;
    localparam int BANK_W      = 32;
    localparam int NUM_BANKS   = NUM_SRC / BANK_W;
    localparam int SRC_W       = $clog2(NUM_SRC);
    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int SRST_CYCLES = 4;
    localparam int SRST_CNT_W  = $clog2(SRST_CYCLES + 1);
    localparam int BANK_STRIDE = 32'h20;

    localparam logic [ADDR_W-1:0] A_REV   = 12'h000;
    localparam logic [ADDR_W-1:0] A_CFG   = 12'h010;
    localparam logic [ADDR_W-1:0] A_STAT  = 12'h014;
    localparam logic [ADDR_W-1:0] A_SORT  = 12'h040;
    localparam logic [ADDR_W-1:0] A_CTRL  = 12'h048;
    localparam logic [ADDR_W-1:0] A_MASK0 = 12'h084;
    localparam logic [ADDR_W-1:0] A_MCLR0 = 12'h088;
    localparam logic [ADDR_W-1:0] A_MSET0 = 12'h08C;
    localparam logic [ADDR_W-1:0] A_PEND0 = 12'h098;

    localparam logic [3:0] REV_MAJOR = 4'd4;
    localparam logic [3:0] REV_MINOR = 4'd0;

    // Interrupt currently presented to the processor
    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] num;
    } cur_t;

    // One bus transfer as seen by the decoder
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic [ADDR_W-1:0] bank_addr(input logic [ADDR_W-1:0] base,
                                                    input int b);
        return base + ADDR_W'(b * BANK_STRIDE);
    endfunction

    // Highest-priority (lowest-numbered) set bit
    function automatic logic [SRC_W-1:0] lowest_src(input logic [NUM_SRC-1:0] v);
        logic [SRC_W-1:0] idx;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) idx = SRC_W'(i);
        end
        return idx;
    endfunction

    function automatic logic [DATA_W-1:0] sorted_word(input cur_t c, input logic still);
        if (c.valid && still)
            return {{(DATA_W-SRC_W){1'b0}}, c.num};
        return {{(DATA_W-SRC_W){1'b1}}, c.num};
    endfunction

endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank
    import intc_pkg::*;
#(
    parameter int W = BANK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            mask <= '1;
        end else if (set_we) begin
            mask <= mask | wdata;
        end else if (clr_we) begin
            mask <= mask & ~wdata;
        end
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_all,
    input  logic               ack,
    input  logic [NUM_SRC-1:0] pend,
    output cur_t               cur
);

    logic any_pend;
    assign any_pend = |pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (clr_all) begin
            cur.valid <= 1'b0;
        end else if (cur.valid) begin
            if (ack) cur.valid <= 1'b0;
        end else if (any_pend) begin
            cur.valid <= 1'b1;
            cur.num   <= lowest_src(pend);
        end
    end

endmodule

// File: rtl/intc_srst_ctl.sv
module intc_srst_ctl
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    output logic       start,
    output logic       busy,
    output logic       autoidle
);

    logic [SRST_CNT_W-1:0] cnt;

    assign start = cfg_we && cfg_wdata[1];
    assign busy  = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= SRST_CNT_W'(SRST_CYCLES);
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            autoidle <= 1'b0;
        end else if (start) begin
            autoidle <= 1'b0;
        end else if (cfg_we) begin
            autoidle <= cfg_wdata[0];
        end
    end

endmodule

// File: rtl/banked_intc.sv
module banked_intc
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);

    bus_req_t           req;
    logic               busy;
    logic               srst_start;
    logic               clr_all;
    logic               autoidle;
    logic               wr_ok;
    logic               ack;
    logic [NUM_SRC-1:0] mask_flat;
    logic [NUM_SRC-1:0] pend_flat;
    cur_t               cur;

    assign req     = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};
    assign wr_ok   = req.wr && !busy;
    assign clr_all = srst_start || busy;
    assign ack     = wr_ok && (req.addr == A_CTRL) && req.data[0];

    intc_srst_ctl u_srst (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (req.wr && (req.addr == A_CFG)),
        .cfg_wdata (req.data[1:0]),
        .start     (srst_start),
        .busy      (busy),
        .autoidle  (autoidle)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] SET_A = bank_addr(A_MSET0, b);
        localparam logic [ADDR_W-1:0] CLR_A = bank_addr(A_MCLR0, b);

        intc_mask_bank #(.W(BANK_W)) u_mask (
            .clk     (clk),
            .rst     (rst),
            .clr_all (clr_all),
            .set_we  (wr_ok && (req.addr == SET_A)),
            .clr_we  (wr_ok && (req.addr == CLR_A)),
            .wdata   (req.data[BANK_W-1:0]),
            .mask    (mask_flat[b*BANK_W +: BANK_W])
        );
    end

    assign pend_flat = src_lvl & ~mask_flat;

    intc_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_all),
        .ack     (ack),
        .pend    (pend_flat),
        .cur     (cur)
    );

    assign irq_out = cur.valid;

    always_comb begin
        bus_rdata = '0;
        if (req.addr == A_REV)  bus_rdata = DATA_W'({REV_MAJOR, REV_MINOR});
        if (req.addr == A_CFG)  bus_rdata = DATA_W'({busy, autoidle});
        if (req.addr == A_STAT) bus_rdata = DATA_W'(!busy);
        if (req.addr == A_SORT) bus_rdata = sorted_word(cur, pend_flat[cur.num]);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (req.addr == bank_addr(A_MASK0, b))
                bus_rdata = DATA_W'(mask_flat[b*BANK_W +: BANK_W]);
            if (req.addr == bank_addr(A_PEND0, b))
                bus_rdata = DATA_W'(pend_flat[b*BANK_W +: BANK_W]);
        end
    end

endmodule

// File: rtl/banked_intc_chk.sv
module banked_intc_chk
    import intc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               irq_out,
    input logic               busy,
    input logic [NUM_SRC-1:0] mask_flat,
    input logic [NUM_SRC-1:0] pend_flat
);

    logic ack_wr;
    logic srst_wr;
    assign ack_wr  = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
    assign srst_wr = bus_wr && (bus_addr == A_CFG) && bus_wdata[1];

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !ack_wr && !srst_wr) |=> irq_out);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(|pend_flat));

    // R8
    srst_busy_chk: assert property (@(posedge clk) disable iff (rst)
        srst_wr |=> busy);

    // R8
    srst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !irq_out);

    // R9
    srst_mask_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (&mask_flat));

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !busy && (bus_addr == A_MSET0))
        |=> ((mask_flat[BANK_W-1:0] & $past(bus_wdata[BANK_W-1:0])) == $past(bus_wdata[BANK_W-1:0])));

endmodule

bind banked_intc banked_intc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .busy      (busy),
    .mask_flat (mask_flat),
    .pend_flat (pend_flat)
);

// File: tb/banked_intc_test.sv
module banked_intc_test;
    import intc_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] src_lvl = '0;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [DATA_W-1:0]  bus_wdata = '0;
    logic [DATA_W-1:0]  bus_rdata;
    logic               irq_out;

    int nchk = 0;
    int nerr = 0;
    logic [NUM_SRC-1:0] mask_m = '1;

    always #4 clk = ~clk;

    banked_intc uut (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int lowest_m(input logic [NUM_SRC-1:0] v);
        for (int i = 0; i < NUM_SRC; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [ADDR_W-1:0] boff(input logic [ADDR_W-1:0] base, input int b);
        return base + ADDR_W'(32 * b);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [NUM_SRC-1:0] pend;
        int lo;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R10, R11, R7 idle
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        for (int b = 0; b < NUM_BANKS; b++) begin
            rd(boff(A_MASK0, b), d); check("R1 mask", d, 32'hFFFF_FFFF);
            rd(boff(A_PEND0, b), d); check("R1 pend", d, 32'h0);
        end
        rd(A_STAT, d); check("R1 status", d, 32'h1);
        rd(A_CFG, d);  check("R10 autoidle reset", d, 32'h0);
        rd(A_REV, d);  check("R11 revision", d, 32'h40);
        rd(A_SORT, d); check("R7 idle sorted", d & 32'hFFFF_FF80, 32'hFFFF_FF80);

        // R3 R4 directed mask edits
        wr(boff(A_MCLR0, 1), 32'h0000_00F0); mask_m[32 +: 32] &= ~32'h0000_00F0;
        rd(boff(A_MASK0, 1), d); check("R4 clear", d, mask_m[32 +: 32]);
        wr(boff(A_MSET0, 1), 32'h0000_0010); mask_m[32 +: 32] |= 32'h0000_0010;
        rd(boff(A_MASK0, 1), d); check("R3 set", d, mask_m[32 +: 32]);
        wr(boff(A_MASK0, 1), 32'h0);
        rd(boff(A_MASK0, 1), d); check("R4 direct write ignored", d, mask_m[32 +: 32]);

        // Random: pending words, selection, mask readback
        for (int it = 0; it < 60; it++) begin
            int b;
            logic [31:0] v;
            b = $urandom % NUM_BANKS;
            v = $urandom & $urandom;
            src_lvl = {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom};
            if ($urandom % 2) begin
                wr(boff(A_MSET0, b), v); mask_m[b*32 +: 32] |= v;
            end else begin
                wr(boff(A_MCLR0, b), v | $urandom); mask_m[b*32 +: 32] &= ~(v | bus_wdata);
            end
            wr(A_CTRL, 32'h1);
            pend = src_lvl & ~mask_m;
            lo = lowest_m(pend);
            rd(boff(A_MASK0, b), d); check("R3 R4 mask readback", d, mask_m[b*32 +: 32]);
            for (int k = 0; k < NUM_BANKS; k++) begin
                rd(boff(A_PEND0, k), d); check("R2 pending", d, pend[k*32 +: 32]);
            end
            check("R5 irq", {31'b0, irq_out}, {31'b0, (pend != '0)});
            rd(A_SORT, d);
            if (lo >= 0) check("R5 sorted", d, 32'(lo));
            else         check("R7 none pending", d & 32'hFFFF_FF80, 32'hFFFF_FF80);
        end

        // R6 freeze and acknowledge sequencing
        for (int b = 0; b < NUM_BANKS; b++) wr(boff(A_MCLR0, b), 32'hFFFF_FFFF);
        mask_m = '0;
        src_lvl = '0;
        wr(A_CTRL, 32'h1);
        src_lvl[40] = 1'b1; src_lvl[70] = 1'b1;
        rd(A_SORT, d); rd(A_SORT, d); check("R5 first select", d, 32'd40);
        src_lvl[3] = 1'b1;
        rd(A_SORT, d); rd(A_SORT, d); check("R6 frozen", d, 32'd40);
        wr(A_CTRL, 32'h0);
        rd(A_SORT, d); check("R6 ack bit0 zero", d, 32'd40);
        src_lvl[40] = 1'b0;
        rd(A_SORT, d); check("R7 spurious", d, 32'hFFFF_FF80 | 32'd40);
        check("R6 irq held", {31'b0, irq_out}, 32'h1);
        wr(A_CTRL, 32'h1);
        rd(A_SORT, d); check("R6 next after ack", d, 32'd3);
        src_lvl[3] = 1'b0;
        wr(A_CTRL, 32'h1);
        rd(A_SORT, d); check("R6 next after ack", d, 32'd70);

        // R10 autoidle, R8 soft reset timing
        wr(A_CFG, 32'h1);
        rd(A_CFG, d); check("R10 autoidle set", d, 32'h1);
        wr(A_CFG, 32'h2);
        rd(A_STAT, d); check("R8 busy c1", d, 32'h0);
        rd(A_STAT, d); check("R8 busy c2", d, 32'h0);
        rd(A_CFG, d);  check("R8 cfg busy bit", d, 32'h2);
        rd(A_STAT, d); check("R8 done", d, 32'h1);
        check("R8 irq dropped", {31'b0, irq_out}, 32'h0);
        rd(A_CFG, d); check("R8 autoidle cleared", d, 32'h0);
        for (int b = 0; b < NUM_BANKS; b++) begin
            rd(boff(A_MASK0, b), d); check("R8 masks restored", d, 32'hFFFF_FFFF);
        end

        // R9 writes ignored during soft reset
        wr(A_CFG, 32'h2);
        wr(A_MCLR0, 32'hFFFF_FFFF);
        repeat (4) @(negedge clk);
        rd(A_MASK0, d); check("R9 write ignored", d, 32'hFFFF_FFFF);
        check("R9 irq low", {31'b0, irq_out}, 32'h0);
        src_lvl[3] = 1'b1;
        wr(A_MCLR0, 32'h0000_0008);
        rd(A_SORT, d); check("R5 select after reset", d, 32'd3);
        check("R5 irq after reset", {31'b0, irq_out}, 32'h1);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule